// File: doc/BRIEF.md
# Bidirectional Three-Bit Counter With Run-Time Wrap or Hold at the Ends

The block is a small free-running counter. It steps once on every rising clock edge, and its register value drives the output directly. One control pin sets the direction of the step: up or down. A second control pin sets what happens at the ends of the range. In wrap mode the count rolls over to the opposite end. In hold mode it stays at the end it has reached.

Either control may be changed on any cycle. The new setting is used at the next edge, and counting goes on from the value the register holds at that moment. The count is never reset by a mode change. A synchronous reset returns the count to zero. The counter width is a parameter whose default is three bits, which gives the range 0 to 7.

Top module: `updown_wrapsat_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count` becomes 0 after that edge, whatever the controls are.
- R2: With `dir_down`=0 and `sat_hold`=0, each edge takes `count` to `count`+1, and 7 is followed by 0.
- R3: With `dir_down`=1 and `sat_hold`=0, each edge takes `count` to `count`-1, and 0 is followed by 7.
- R4: With `dir_down`=0 and `sat_hold`=1, `count` rises by one per edge up to 7 and then stays at 7.
- R5: With `dir_down`=1 and `sat_hold`=1, `count` falls by one per edge down to 0 and then stays at 0.
- R6: A change of `dir_down` or `sat_hold` is applied at the next edge, starting from the current `count`. This includes changes made while `count` is 0 or 7.
- R7: When the count is held at an end in hold mode and the direction is reversed, the next edge moves `count` one step away from that end (7 to 6, or 0 to 1).
- R8: Out of reset, every edge either changes `count` by exactly one step (modulo 8), or leaves it unchanged. It is left unchanged only in hold mode, when the count already sits at the end it is moving toward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| sat_hold | input | 1 | 0 = wrap at the ends, 1 = hold at the ends |
| count | output | 3 | Current counter value |

## Verification
The hardest situations to reach are a control change that arrives on the same cycle the count sits at 0 or 7. Examples are a switch into hold mode exactly at the end, or a reversal while the count is held. Uniform random stimulus lands there only rarely. Directed sequences therefore drive the count to each end and then toggle each control there. The random phase holds each mode for long runs, so the count often reaches an end before the next change.

// File: rtl/udc_pkg.sv
package udc_pkg;

    localparam int unsigned CNT_W = 3;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic {
        END_WRAP = 1'b0,
        END_HOLD = 1'b1
    } end_policy_e;

endpackage

// File: rtl/udc_limits.sv
module udc_limits #(
    parameter int unsigned WIDTH = udc_pkg::CNT_W
) (
    input  logic [WIDTH-1:0] cur,
    output logic             at_top,
    output logic             at_bottom,
    output logic [WIDTH-1:0] plus_one,
    output logic [WIDTH-1:0] minus_one
);
    localparam logic [WIDTH-1:0] TOP    = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOTTOM = '0;
    localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

    always_comb begin
        at_top    = (cur == TOP);
        at_bottom = (cur == BOTTOM);
        plus_one  = cur + ONE;
        minus_one = cur - ONE;
    end
endmodule

// File: rtl/udc_select.sv
module udc_select #(
    parameter int unsigned WIDTH = udc_pkg::CNT_W
) (
    input  udc_pkg::dir_e        dir,
    input  udc_pkg::end_policy_e policy,
    input  logic [WIDTH-1:0]     cur,
    input  logic                 at_top,
    input  logic                 at_bottom,
    input  logic [WIDTH-1:0]     plus_one,
    input  logic [WIDTH-1:0]     minus_one,
    output logic [WIDTH-1:0]     nxt
);
    import udc_pkg::*;

    logic pinned;

    always_comb begin
        pinned = 1'b0;
        if (policy == END_HOLD) begin
            pinned = (dir == DIR_UP) ? at_top : at_bottom;
        end
        if (pinned) begin
            nxt = cur;
        end else if (dir == DIR_UP) begin
            nxt = plus_one;
        end else begin
            nxt = minus_one;
        end
    end
endmodule

// File: rtl/updown_wrapsat_counter.sv
module updown_wrapsat_counter #(
    parameter int unsigned WIDTH = udc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_down,
    input  logic             sat_hold,
    output logic [WIDTH-1:0] count
);
    import udc_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } cnt_state_t;

    cnt_state_t  st_d;
    cnt_state_t  st_q;

    dir_e        dir_sel;
    end_policy_e end_sel;
    logic        at_top;
    logic        at_bottom;
    logic [WIDTH-1:0] plus_one;
    logic [WIDTH-1:0] minus_one;
    logic [WIDTH-1:0] step_nxt;

    assign dir_sel = dir_e'(dir_down);
    assign end_sel = end_policy_e'(sat_hold);

    udc_limits #(.WIDTH(WIDTH)) u_limits (
        .cur       (st_q.value),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .plus_one  (plus_one),
        .minus_one (minus_one)
    );

    udc_select #(.WIDTH(WIDTH)) u_select (
        .dir       (dir_sel),
        .policy    (end_sel),
        .cur       (st_q.value),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .plus_one  (plus_one),
        .minus_one (minus_one),
        .nxt       (step_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.value = '0;
        end else begin
            st_d.value = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.value;
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
    parameter int unsigned WIDTH = udc_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             dir_down,
    input logic             sat_hold,
    input logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R2
    up_wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_down && !sat_hold) |=> (count == $past(count) + ONE));

    // R3
    down_wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_down && !sat_hold) |=> (count == $past(count) - ONE));

    // R4
    up_hold_top_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_down && sat_hold && count == TOP) |=> (count == TOP));

    // R5
    down_hold_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_down && sat_hold && count == '0) |=> (count == '0));

    // R7
    leave_top_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_down && sat_hold && count == TOP) |=> (count == TOP - ONE));

    // R7
    leave_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_down && sat_hold && count == '0) |=> (count == ONE));
endmodule

bind updown_wrapsat_counter udc_checker #(.WIDTH(WIDTH)) u_udc_checker (
    .clk      (clk),
    .rst      (rst),
    .dir_down (dir_down),
    .sat_hold (sat_hold),
    .count    (count)
);

// File: tb/tb_updown_wrapsat_counter.sv
module tb_updown_wrapsat_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_down = 1'b0;
    logic       sat_hold = 1'b0;
    logic [2:0] count;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [2:0]  expv     = 3'd0;
    bit          finished = 1'b0;

    updown_wrapsat_counter dut (
        .clk      (clk),
        .rst      (rst),
        .dir_down (dir_down),
        .sat_hold (sat_hold),
        .count    (count)
    );

    always #2 clk = ~clk;

    function automatic logic [2:0] model_next(input logic [2:0] c, input logic dn, input logic hold);
        if (!dn) begin
            if (hold && c == 3'd7) return c;
            return c + 3'd1;
        end
        if (hold && c == 3'd0) return c;
        return c - 3'd1;
    endfunction

    function automatic string mode_tag(input logic [2:0] c, input logic dn, input logic hold);
        if (hold && ((dn && c == 3'd7) || (!dn && c == 3'd0))) return "R7";
        case ({dn, hold})
            2'b00:   return "R2";
            2'b10:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Drive controls at the falling edge, then sample 1 ns after the rising edge.
    task automatic step(input logic dn, input logic hold, input string tag_override);
        string tag;
        @(negedge clk);
        dir_down = dn;
        sat_hold = hold;
        rst      = 1'b0;
        tag = (tag_override != "") ? tag_override : mode_tag(expv, dn, hold);
        expv = model_next(expv, dn, hold);
        @(posedge clk);
        #1;
        check(tag, count, expv);
    endtask

    task automatic do_reset(input logic dn, input logic hold);
        @(negedge clk);
        rst      = 1'b1;
        dir_down = dn;
        sat_hold = hold;
        @(posedge clk);
        #1;
        expv = 3'd0;
        check("R1", count, 3'd0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: count=%0d expected=%0d", count, expv);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2718);

        do_reset(1'b0, 1'b0);
        do_reset(1'b1, 1'b1);

        // R2: up with wrap, through 7 -> 0
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R2");
        // R3: down with wrap, through 0 -> 7
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R3");

        // R4: climb and hold at 7
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R4");
        // R7: reverse at 7 while holding
        step(1'b1, 1'b1, "R7");
        // R6: back up, then switch to wrap mode at 7
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, "R6");   // 7 -> 0 now that wrap is selected

        // R5: descend in hold mode from 0: stays at 0
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        // R7: reverse at 0 while holding
        step(1'b0, 1'b1, "R7");
        // R6: go to 0, then switch to wrap down while at 0
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");   // 0 -> 7
        // R6: switch to hold up while at 7
        step(1'b0, 1'b1, "R6");

        // R1: reset mid-run overrides the controls
        do_reset(1'b0, 1'b0);

        // R8: random runs of held modes
        for (int blk = 0; blk < 300; blk++) begin
            logic dn;
            logic hold;
            int   len;
            dn   = 1'($urandom);
            hold = ($urandom % 3) != 0;
            len  = 1 + ($urandom % 12);
            for (int k = 0; k < len; k++) begin
                step(dn, hold, "R8");
            end
            if (($urandom % 40) == 0) do_reset(1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule